// File: doc/BRIEF.md
# Display Panel Power-Up Sequencer

This block takes a command-mode display panel through a full power cycle as one ordered sequence. On a power-up request it turns on the analog rail and then the I/O rail. It waits for the rails to settle and pulses the panel's active-low reset line. It then sends a fixed list of panel initialization commands one byte at a time over a valid/ready command port, with a programmable wait after each command. On a power-down request it sends the shutdown commands, sets the link low-power flag again, pulls reset low and removes the rails in the opposite order from power-up.

Every wait is counted in milliseconds. A clock divider sets the length of one millisecond. A reduced power-up request turns on the rails and releases reset, but sends no reset pulse and no commands. This mode is meant for a panel that an earlier boot stage left running. The block drives only the enables, reset and flags, and it waits out fixed intervals. Link framing, checksums and the regulators themselves are outside this block.

Top module: `pnl_pwr_seq`

## Requirements
- R1: After reset: `avdd_en`=0, `iovdd_en`=0, `panel_rst_n`=0, `lp_mode`=1, `cmd_valid`=0, `busy`=0, `done`=0.
- R2: On a power-up request, `avdd_en` rises at least one cycle before `iovdd_en`. `iovdd_en` is never high while `avdd_en` is low. The first rise of `panel_rst_n` comes T_PWR_MS milliseconds after `iovdd_en` rises, plus no more than a few cycles.
- R3: In a full power-up, `panel_rst_n` goes high, then low, then high, and each phase lasts T_RST_MS milliseconds. No command byte is offered until T_RST_MS milliseconds after the final rise. `cmd_valid` is only ever high while `panel_rst_n` and `iovdd_en` are both high.
- R4: The power-up list is sent in this order, one byte per handshake:
  - B9 FF 83 94 (unlock, long);
  - B1 3C 12 (long);
  - a long write of GAMMA_LEN bytes, E0 followed by bytes 8*(k-1)+4 for k=1..GAMMA_LEN-1;
  - 11 (short);
  - 29 (short).
  Alongside each byte, `cmd_last` marks the final byte of its command, `cmd_long` is 1 for a long write, and `cmd_len` carries the byte count of the command. While `cmd_valid` is high and `cmd_ready` is low, all of these hold their values.
- R5: `lp_mode` is low by the time the first power-up byte is accepted. It rises again only after the last power-down byte, in the same cycle that `panel_rst_n` falls.
- R6: After the 11 byte is accepted, no further byte is accepted for DLY_SLPOUT_MS milliseconds. After the 29 byte is accepted, `done` waits at least DLY_DISPON_MS milliseconds.
- R7: A power-up request with `on_reduced`=1 turns on both rails and raises `panel_rst_n` once, with no low pulse. It offers no command, leaves `lp_mode` high and then pulses `done`.
- R8: A power-down request sends 10 (short), waits DLY_SLPIN_MS milliseconds, then sends 28 (short). After that, `lp_mode` rises and `panel_rst_n` falls. `iovdd_en` then falls strictly before `avdd_en`.
- R9: `done` is a single-cycle pulse in the cycle that `busy` drops. Requests that arrive while `busy` is high are ignored. A power-up request is ignored while the rails are already on, and a power-down request is ignored while they are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Power-up request pulse |
| on_reduced | input | 1 | Sampled with `on_req`; 1 selects reduced power-up |
| off_req | input | 1 | Power-down request pulse |
| cmd_ready | input | 1 | Command sink can accept a byte |
| avdd_en | output | 1 | Analog rail enable |
| iovdd_en | output | 1 | I/O rail enable |
| panel_rst_n | output | 1 | Panel reset, active low |
| lp_mode | output | 1 | Link low-power flag |
| cmd_valid | output | 1 | Command byte is valid |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final byte of the current command |
| cmd_long | output | 1 | Current command is a long write |
| cmd_len | output | LEN_W | Byte count of the current command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_PER_MS=4, so each millisecond lasts four cycles. This keeps the 200 ms post-command waits and the 10 ms reset phases short enough that every exact window can be measured in cycles and bounded tightly. GAMMA_LEN is set to 6 rather than the default 8. This shows that the generated ramp command follows the parameter in its length, its `cmd_len` and the position of its last-byte marker. The command sink drops ready for two out of every five cycles, so each command stalls partway through and the hold rules are exercised.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;

   localparam int ENT_W = 3;

   localparam logic [ENT_W-1:0] ENT_UNLOCK  = 3'd0;
   localparam logic [ENT_W-1:0] ENT_PANEL   = 3'd1;
   localparam logic [ENT_W-1:0] ENT_RAMP    = 3'd2;
   localparam logic [ENT_W-1:0] ENT_WAKE    = 3'd3;
   localparam logic [ENT_W-1:0] ENT_SHOW    = 3'd4;
   localparam logic [ENT_W-1:0] ENT_SLEEP   = 3'd5;
   localparam logic [ENT_W-1:0] ENT_BLANK   = 3'd6;

   localparam logic [ENT_W-1:0] ON_FIRST  = ENT_UNLOCK;
   localparam logic [ENT_W-1:0] ON_LAST   = ENT_SHOW;
   localparam logic [ENT_W-1:0] OFF_FIRST = ENT_SLEEP;
   localparam logic [ENT_W-1:0] OFF_LAST  = ENT_BLANK;

   localparam logic [7:0] OP_WAKE  = 8'h11;
   localparam logic [7:0] OP_SHOW  = 8'h29;
   localparam logic [7:0] OP_SLEEP = 8'h10;
   localparam logic [7:0] OP_BLANK = 8'h28;
   localparam logic [7:0] OP_RAMP  = 8'hE0;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_IO_ON,
      ST_PWR_WAIT,
      ST_RST_HI1,
      ST_RST_LO,
      ST_RST_HI2,
      ST_SEND,
      ST_POST,
      ST_IO_OFF,
      ST_A_OFF
   } seq_state_t;

endpackage

// File: rtl/pnl_ms_timer.sv
module pnl_ms_timer #(
   parameter int CLK_PER_MS = 100000,
   parameter int MS_W       = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [MS_W-1:0] load_ms,
   output logic            busy
);

   localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

   logic [MS_W-1:0] ms_cnt;
   logic            step;

   generate
      if (CLK_PER_MS == 1) begin : g_direct
         assign step = 1'b1;
      end else begin : g_prescale
         logic [PRE_W-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre <= '0;
            end else if (load || (ms_cnt == '0)) begin
               pre <= '0;
            end else if (pre == PRE_W'(CLK_PER_MS - 1)) begin
               pre <= '0;
            end else begin
               pre <= pre + 1'b1;
            end
         end
         assign step = (pre == PRE_W'(CLK_PER_MS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_cnt <= '0;
      end else if (load) begin
         ms_cnt <= load_ms;
      end else if ((ms_cnt != '0) && step) begin
         ms_cnt <= ms_cnt - 1'b1;
      end
   end

   assign busy = load | (ms_cnt != '0);

endmodule

// File: rtl/pnl_cmd_rom.sv
module pnl_cmd_rom
   import pnl_seq_pkg::*;
#(
   parameter int LEN_W         = 6,
   parameter int MS_W          = 10,
   parameter int GAMMA_LEN     = 8,
   parameter int DLY_SLPOUT_MS = 120,
   parameter int DLY_DISPON_MS = 200,
   parameter int DLY_SLPIN_MS  = 200
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [LEN_W-1:0] idx,
   output logic [7:0]       data,
   output logic [LEN_W-1:0] len,
   output logic             is_long,
   output logic [MS_W-1:0]  delay_ms
);

   logic [7:0] ramp_k;

   assign ramp_k = 8'(idx) - 8'd1;

   always_comb begin
      data     = 8'h00;
      len      = LEN_W'(1);
      is_long  = 1'b0;
      delay_ms = '0;
      case (entry)
         ENT_UNLOCK: begin
            len     = LEN_W'(4);
            is_long = 1'b1;
            case (idx[1:0])
               2'd0:    data = 8'hB9;
               2'd1:    data = 8'hFF;
               2'd2:    data = 8'h83;
               default: data = 8'h94;
            endcase
         end
         ENT_PANEL: begin
            len     = LEN_W'(3);
            is_long = 1'b1;
            if (idx == '0)              data = 8'hB1;
            else if (idx == LEN_W'(1))  data = 8'h3C;
            else                        data = 8'h12;
         end
         ENT_RAMP: begin
            len     = LEN_W'(GAMMA_LEN);
            is_long = 1'b1;
            if (idx == '0) data = OP_RAMP;
            else           data = (ramp_k << 3) + 8'd4;
         end
         ENT_WAKE: begin
            data     = OP_WAKE;
            delay_ms = MS_W'(DLY_SLPOUT_MS);
         end
         ENT_SHOW: begin
            data     = OP_SHOW;
            delay_ms = MS_W'(DLY_DISPON_MS);
         end
         ENT_SLEEP: begin
            data     = OP_SLEEP;
            delay_ms = MS_W'(DLY_SLPIN_MS);
         end
         ENT_BLANK: begin
            data = OP_BLANK;
         end
         default: begin
            data = 8'h00;
         end
      endcase
   end

endmodule

// File: rtl/pnl_cmd_stream.sv
module pnl_cmd_stream #(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   input  logic             ready,
   output logic             valid,
   output logic             last,
   output logic [LEN_W-1:0] idx,
   output logic             fin
);

   logic active;

   assign valid = active;
   assign last  = active && (idx == (len - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            active <= 1'b1;
            idx    <= '0;
         end else if (active && ready) begin
            if (last) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
   import pnl_seq_pkg::*;
#(
   parameter int CLK_PER_MS    = 100000,
   parameter int MS_W          = 10,
   parameter int LEN_W         = 6,
   parameter int GAMMA_LEN     = 8,
   parameter int T_PWR_MS      = 10,
   parameter int T_RST_MS      = 10,
   parameter int DLY_SLPOUT_MS = 120,
   parameter int DLY_DISPON_MS = 200,
   parameter int DLY_SLPIN_MS  = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_req,
   input  logic             on_reduced,
   input  logic             off_req,
   input  logic             cmd_ready,
   output logic             avdd_en,
   output logic             iovdd_en,
   output logic             panel_rst_n,
   output logic             lp_mode,
   output logic             cmd_valid,
   output logic [7:0]       cmd_data,
   output logic             cmd_last,
   output logic             cmd_long,
   output logic [LEN_W-1:0] cmd_len,
   output logic             busy,
   output logic             done
);

   localparam int MS_MAX = (1 << MS_W) - 1;

   generate
      if (CLK_PER_MS < 1) begin : g_bad_div
         $error("CLK_PER_MS must be at least 1");
      end
      if (GAMMA_LEN < 2 || GAMMA_LEN >= (1 << LEN_W)) begin : g_bad_ramp
         $error("GAMMA_LEN must be between 2 and 2**LEN_W-1");
      end
      if (T_PWR_MS > MS_MAX || T_RST_MS > MS_MAX || DLY_SLPOUT_MS > MS_MAX ||
          DLY_DISPON_MS > MS_MAX || DLY_SLPIN_MS > MS_MAX) begin : g_bad_dly
         $error("a delay does not fit in MS_W bits");
      end
   endgenerate

   seq_state_t       state;
   logic [ENT_W-1:0] entry;
   logic             reduced_q;
   logic             tmr_load;
   logic [MS_W-1:0]  tmr_ms;
   logic             tmr_busy;
   logic             str_start;
   logic             str_valid;
   logic             str_last;
   logic             str_fin;
   logic [LEN_W-1:0] byte_idx;
   logic [7:0]       rom_data;
   logic [LEN_W-1:0] rom_len;
   logic             rom_long;
   logic [MS_W-1:0]  rom_dly;

   pnl_ms_timer #(
      .CLK_PER_MS (CLK_PER_MS),
      .MS_W       (MS_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_ms (tmr_ms),
      .busy    (tmr_busy)
   );

   pnl_cmd_rom #(
      .LEN_W         (LEN_W),
      .MS_W          (MS_W),
      .GAMMA_LEN     (GAMMA_LEN),
      .DLY_SLPOUT_MS (DLY_SLPOUT_MS),
      .DLY_DISPON_MS (DLY_DISPON_MS),
      .DLY_SLPIN_MS  (DLY_SLPIN_MS)
   ) u_rom (
      .entry    (entry),
      .idx      (byte_idx),
      .data     (rom_data),
      .len      (rom_len),
      .is_long  (rom_long),
      .delay_ms (rom_dly)
   );

   pnl_cmd_stream #(
      .LEN_W (LEN_W)
   ) u_stream (
      .clk   (clk),
      .rst_n (rst_n),
      .start (str_start),
      .len   (rom_len),
      .ready (cmd_ready),
      .valid (str_valid),
      .last  (str_last),
      .idx   (byte_idx),
      .fin   (str_fin)
   );

   assign cmd_valid = str_valid;
   assign cmd_last  = str_last;
   assign cmd_data  = str_valid ? rom_data : 8'h00;
   assign cmd_long  = str_valid & rom_long;
   assign cmd_len   = str_valid ? rom_len : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         entry       <= ON_FIRST;
         reduced_q   <= 1'b0;
         avdd_en     <= 1'b0;
         iovdd_en    <= 1'b0;
         panel_rst_n <= 1'b0;
         lp_mode     <= 1'b1;
         busy        <= 1'b0;
         done        <= 1'b0;
         tmr_load    <= 1'b0;
         tmr_ms      <= '0;
         str_start   <= 1'b0;
      end else begin
         done      <= 1'b0;
         tmr_load  <= 1'b0;
         str_start <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (on_req && !avdd_en) begin
                  avdd_en   <= 1'b1;
                  busy      <= 1'b1;
                  reduced_q <= on_reduced;
                  state     <= ST_IO_ON;
               end else if (off_req && avdd_en) begin
                  busy      <= 1'b1;
                  entry     <= OFF_FIRST;
                  str_start <= 1'b1;
                  state     <= ST_SEND;
               end
            end
            ST_IO_ON: begin
               iovdd_en <= 1'b1;
               tmr_load <= 1'b1;
               tmr_ms   <= MS_W'(T_PWR_MS);
               state    <= ST_PWR_WAIT;
            end
            ST_PWR_WAIT: begin
               if (!tmr_busy) begin
                  panel_rst_n <= 1'b1;
                  if (reduced_q) begin
                     busy  <= 1'b0;
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     tmr_load <= 1'b1;
                     tmr_ms   <= MS_W'(T_RST_MS);
                     state    <= ST_RST_HI1;
                  end
               end
            end
            ST_RST_HI1: begin
               if (!tmr_busy) begin
                  panel_rst_n <= 1'b0;
                  tmr_load    <= 1'b1;
                  tmr_ms      <= MS_W'(T_RST_MS);
                  state       <= ST_RST_LO;
               end
            end
            ST_RST_LO: begin
               if (!tmr_busy) begin
                  panel_rst_n <= 1'b1;
                  tmr_load    <= 1'b1;
                  tmr_ms      <= MS_W'(T_RST_MS);
                  state       <= ST_RST_HI2;
               end
            end
            ST_RST_HI2: begin
               if (!tmr_busy) begin
                  lp_mode   <= 1'b0;
                  entry     <= ON_FIRST;
                  str_start <= 1'b1;
                  state     <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (str_fin) begin
                  tmr_load <= 1'b1;
                  tmr_ms   <= rom_dly;
                  state    <= ST_POST;
               end
            end
            ST_POST: begin
               if (!tmr_busy) begin
                  if (entry == ON_LAST) begin
                     busy  <= 1'b0;
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else if (entry == OFF_LAST) begin
                     lp_mode     <= 1'b1;
                     panel_rst_n <= 1'b0;
                     state       <= ST_IO_OFF;
                  end else begin
                     entry     <= entry + 1'b1;
                     str_start <= 1'b1;
                     state     <= ST_SEND;
                  end
               end
            end
            ST_IO_OFF: begin
               iovdd_en <= 1'b0;
               state    <= ST_A_OFF;
            end
            ST_A_OFF: begin
               avdd_en <= 1'b0;
               busy    <= 1'b0;
               done    <= 1'b1;
               state   <= ST_IDLE;
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/pnl_pwr_seq_chk.sv
module pnl_pwr_seq_chk #(
   parameter int LEN_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_ready,
   input logic             avdd_en,
   input logic             iovdd_en,
   input logic             panel_rst_n,
   input logic             lp_mode,
   input logic             cmd_valid,
   input logic [7:0]       cmd_data,
   input logic             cmd_last,
   input logic             cmd_long,
   input logic [LEN_W-1:0] cmd_len,
   input logic             busy,
   input logic             done
);

   // R2: I/O rail only with analog rail present
   p_supply_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iovdd_en |-> avdd_en);

   // R3: bytes only with rails up and reset released
   p_cmd_rails_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (panel_rst_n && iovdd_en));

   // R4: a stalled byte holds still
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data) &&
         $stable(cmd_last) && $stable(cmd_long) && $stable(cmd_len)));

   // R5: low-power flag returns only with reset driven low and the port quiet
   p_lp_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lp_mode) |-> (!panel_rst_n && !cmd_valid));

   // R9: completion is a single pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: completion coincides with busy dropping
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind pnl_pwr_seq pnl_pwr_seq_chk #(.LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_ready   (cmd_ready),
   .avdd_en     (avdd_en),
   .iovdd_en    (iovdd_en),
   .panel_rst_n (panel_rst_n),
   .lp_mode     (lp_mode),
   .cmd_valid   (cmd_valid),
   .cmd_data    (cmd_data),
   .cmd_last    (cmd_last),
   .cmd_long    (cmd_long),
   .cmd_len     (cmd_len),
   .busy        (busy),
   .done        (done)
);

// File: tb/pnl_pwr_seq_tb.sv
module pnl_pwr_seq_tb;

   localparam int CPM   = 4;
   localparam int GLEN  = 6;
   localparam int LEN_W = 6;
   localparam int MS    = CPM;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             on_req = 1'b0;
   logic             on_reduced = 1'b0;
   logic             off_req = 1'b0;
   logic             cmd_ready = 1'b0;
   logic             avdd_en, iovdd_en, panel_rst_n, lp_mode;
   logic             cmd_valid, cmd_last, cmd_long, busy, done;
   logic [7:0]       cmd_data;
   logic [LEN_W-1:0] cmd_len;

   always #2 clk = ~clk;

   pnl_pwr_seq #(
      .CLK_PER_MS (CPM),
      .GAMMA_LEN  (GLEN)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .on_req (on_req), .on_reduced (on_reduced),
      .off_req (off_req), .cmd_ready (cmd_ready), .avdd_en (avdd_en),
      .iovdd_en (iovdd_en), .panel_rst_n (panel_rst_n), .lp_mode (lp_mode),
      .cmd_valid (cmd_valid), .cmd_data (cmd_data), .cmd_last (cmd_last),
      .cmd_long (cmd_long), .cmd_len (cmd_len), .busy (busy), .done (done)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rdy_ph = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      rdy_ph = (rdy_ph == 4) ? 0 : rdy_ph + 1;
      cmd_ready = !(rdy_ph == 2 || rdy_ph == 3);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard: {len, long, last, data}
   logic [15:0] exp_q[$];

   task automatic push_cmd(input logic [7:0] b[], input bit lng);
      for (int k = 0; k < b.size(); k++)
         exp_q.push_back({2'b00, 6'(b.size()), lng, (k == b.size() - 1), b[k]});
   endtask

   task automatic push_on_list();
      logic [7:0] ramp[];
      push_cmd('{8'hB9, 8'hFF, 8'h83, 8'h94}, 1'b1);
      push_cmd('{8'hB1, 8'h3C, 8'h12}, 1'b1);
      ramp = new[GLEN];
      ramp[0] = 8'hE0;
      for (int k = 1; k < GLEN; k++) ramp[k] = 8'(8 * (k - 1) + 4);
      push_cmd(ramp, 1'b1);
      push_cmd('{8'h11}, 1'b0);
      push_cmd('{8'h29}, 1'b0);
   endtask

   task automatic push_off_list();
      push_cmd('{8'h10}, 1'b0);
      push_cmd('{8'h28}, 1'b0);
   endtask

   // monitor state
   bit p_avdd = 0, p_io = 0, p_prst = 0, p_lp = 1, p_done = 0;
   int t_a_rise, t_a_fall, t_io_rise, t_io_fall, t_lp_rise, t_prst_fall;
   int rise_cnt, fall_cnt, t_r1, t_r2, t_r3, t_f1;
   int hs_cnt, t_first_hs, t_h11, t_h29, t_h10, t_h28, t_after11, t_done;
   bit lp_first, after11_pending, done_seen, done_wide;

   task automatic clear_mon();
      rise_cnt = 0; fall_cnt = 0; hs_cnt = 0; done_seen = 0; done_wide = 0;
      after11_pending = 0; t_after11 = 0; t_h11 = 0; t_h29 = 0; t_h10 = 0; t_h28 = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (avdd_en && !p_avdd) t_a_rise = cyc;
         if (!avdd_en && p_avdd) t_a_fall = cyc;
         if (iovdd_en && !p_io) t_io_rise = cyc;
         if (!iovdd_en && p_io) t_io_fall = cyc;
         if (lp_mode && !p_lp) t_lp_rise = cyc;
         if (panel_rst_n && !p_prst) begin
            rise_cnt++;
            if (rise_cnt == 1) t_r1 = cyc;
            else if (rise_cnt == 2) t_r2 = cyc;
         end
         if (!panel_rst_n && p_prst) begin
            fall_cnt++;
            t_f1 = cyc;
            t_prst_fall = cyc;
         end
         if (done) begin
            if (p_done) done_wide = 1;
            done_seen = 1;
            t_done = cyc;
         end
         if (cmd_valid && cmd_ready) begin
            logic [15:0] got;
            hs_cnt++;
            got = {2'b00, cmd_len, cmd_long, cmd_last, cmd_data};
            if (hs_cnt == 1) begin
               t_first_hs = cyc;
               lp_first = lp_mode;
            end
            if (after11_pending) begin
               t_after11 = cyc;
               after11_pending = 0;
            end
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected byte", int'(got), 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk(got == e, "R4 byte/len/type/last", int'(got), int'(e));
            end
            if (cmd_data == 8'h11) begin t_h11 = cyc; after11_pending = 1; end
            if (cmd_data == 8'h29) t_h29 = cyc;
            if (cmd_data == 8'h10) t_h10 = cyc;
            if (cmd_data == 8'h28) t_h28 = cyc;
         end
         p_avdd = avdd_en; p_io = iovdd_en; p_prst = panel_rst_n;
         p_lp = lp_mode; p_done = done;
      end
   end

   task automatic pulse(input bit on, input bit red, input bit off);
      @(posedge clk); #1;
      on_req = on; on_reduced = red; off_req = off;
      @(posedge clk); #1;
      on_req = 0; on_reduced = 0; off_req = 0;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!done_seen && n < 20000) begin
         @(posedge clk);
         n++;
      end
      chk(done_seen, tag, 0, 1);
      @(negedge clk);
   endtask

   task automatic in_range(input string tag, input int v, input int lo, input int hi);
      chk(v >= lo && v <= hi, tag, v, lo);
   endtask

   initial begin
      #(4 * 190000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk({avdd_en, iovdd_en, panel_rst_n, lp_mode, cmd_valid, busy, done} == 7'b0001000,
          "R1 reset outputs", {avdd_en, iovdd_en, panel_rst_n, lp_mode, cmd_valid, busy, done},
          7'b0001000);
      @(posedge clk); #1 rst_n = 1;
      repeat (3) @(posedge clk);

      // full power-up
      clear_mon();
      push_on_list();
      pulse(1, 0, 0);
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy during power-up", busy, 1);
      wait_done("R9 power-up completes");
      chk(t_io_rise > t_a_rise, "R2 analog before io", t_io_rise, t_a_rise + 1);
      in_range("R2 settle before reset", t_r1 - t_io_rise, 10 * MS, 10 * MS + 4);
      chk(rise_cnt == 2 && fall_cnt == 1, "R3 reset edge count", rise_cnt * 16 + fall_cnt, 33);
      in_range("R3 first high phase", t_f1 - t_r1, 10 * MS, 10 * MS + 4);
      in_range("R3 low phase", t_r2 - t_f1, 10 * MS, 10 * MS + 4);
      in_range("R3 wait before first byte", t_first_hs - t_r2, 10 * MS, 10 * MS + 8);
      chk(lp_first == 1'b0, "R5 lp low at first byte", lp_first, 0);
      chk(exp_q.size() == 0, "R4 on-list drained", exp_q.size(), 0);
      chk(hs_cnt == 9 + GLEN, "R4 byte count", hs_cnt, 9 + GLEN);
      in_range("R6 wait after wake", t_after11 - t_h11, 120 * MS, 120 * MS + 12);
      in_range("R6 wait after display-on", t_done - t_h29, 200 * MS, 200 * MS + 12);
      chk(!done_wide, "R9 done single pulse", done_wide, 0);
      chk({avdd_en, iovdd_en, panel_rst_n, lp_mode, busy} == 5'b11100, "R4 on state",
          {avdd_en, iovdd_en, panel_rst_n, lp_mode, busy}, 5'b11100);

      // R9 power-up while on is ignored
      clear_mon();
      pulse(1, 0, 0);
      repeat (60) @(posedge clk);
      @(negedge clk);
      chk(!busy && hs_cnt == 0 && !done_seen && rise_cnt == 0 && fall_cnt == 0,
          "R9 on request while on ignored", hs_cnt + busy, 0);

      // power-down, with a power-up request while busy
      clear_mon();
      push_off_list();
      pulse(0, 0, 1);
      repeat (100) @(posedge clk);
      pulse(1, 0, 0);
      wait_done("R8 power-down completes");
      chk(exp_q.size() == 0, "R8 off-list drained", exp_q.size(), 0);
      in_range("R8 wait after sleep-in", t_h28 - t_h10, 200 * MS, 200 * MS + 12);
      chk(t_lp_rise > t_h28 && t_lp_rise == t_prst_fall, "R5 lp back with reset low",
          t_lp_rise, t_prst_fall);
      chk(t_io_fall > t_prst_fall && t_a_fall > t_io_fall, "R8 rail-off order",
          t_a_fall - t_io_fall, 1);
      repeat (50) @(posedge clk);
      @(negedge clk);
      chk({avdd_en, iovdd_en, panel_rst_n, lp_mode, busy} == 5'b00010,
          "R9 request during power-down ignored", {avdd_en, iovdd_en, panel_rst_n, lp_mode, busy},
          5'b00010);

      // R9 power-down while off is ignored
      clear_mon();
      pulse(0, 0, 1);
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk(!busy && hs_cnt == 0 && !done_seen, "R9 off request while off ignored", busy, 0);

      // reduced power-up
      clear_mon();
      pulse(1, 1, 0);
      wait_done("R7 reduced power-up completes");
      chk({avdd_en, iovdd_en, panel_rst_n, lp_mode} == 4'b1111, "R7 rails up, reset high",
          {avdd_en, iovdd_en, panel_rst_n, lp_mode}, 4'b1111);
      chk(rise_cnt == 1 && fall_cnt == 0, "R7 no reset pulse", rise_cnt * 16 + fall_cnt, 16);
      chk(hs_cnt == 0, "R7 no commands", hs_cnt, 0);
      in_range("R2 reduced settle", t_r1 - t_io_rise, 10 * MS, 10 * MS + 4);

      // power-down from reduced
      clear_mon();
      push_off_list();
      pulse(0, 0, 1);
      wait_done("R8 power-down after reduced");
      chk({avdd_en, iovdd_en, panel_rst_n, lp_mode} == 4'b0001, "R8 final off state",
          {avdd_en, iovdd_en, panel_rst_n, lp_mode}, 4'b0001);
      chk(hs_cnt == 2 && exp_q.size() == 0, "R8 two off bytes", hs_cnt, 2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule